// File: doc/BRIEF.md
# Trimmed Real-Time Prescaler

This block divides a slow source clock down to the tick that advances a real-time counter. Along the way it can be trimmed in fine steps, so a crystal that runs a little fast or slow can be corrected without touching the counter. A signed trim value sets both the size and the direction of the correction. The block then adds or removes single prescaler counts near the end of every correction period. With the default parameters, one correction unit is worth about one part per million.

Beside the tick, the block gives a one-cycle pulse for each selected prescaler bit when that bit rises. These pulses serve as low-rate periodic events. They follow the trimmed count, so an event interval that spans an adjustment comes out one count shorter or longer.

A correction period is `NUM_SUB` sub-periods of `2**SUB_W` source cycles each. The defaults, 976 × 1024 source cycles, give a step of about 1.0006 ppm. A trim write is held as pending and becomes active only when a new correction period starts.

Top module: `rtc_trim_presc`

## Requirements
- R1: After reset, the tick and all event outputs are low and the prescaler is zero. With no correction, the first tick follows exactly `2**PRESC_W` enabled cycles.
- R2: With zero correction, tick pulses are exactly `2**PRESC_W` enabled cycles apart, and each pulse lasts one cycle.
- R3: While `en_i` is low, the prescaler and the correction-period position hold, and the tick and events stay low. Counting resumes from the held state.
- R4: When the active sign bit (the MSB of the trim word) is 0 and the magnitude m (the lower `MAG_W` bits) is non-zero, the prescaler advances by two on the first cycle of each of the last m sub-periods. This gives m extra counts per period, so the output runs faster.
- R5: When the active sign bit is 1 and the magnitude m is non-zero, the prescaler holds for one cycle at the first cycle of each of the last m sub-periods. This removes m counts per period, so the output runs slower.
- R6: A trim write is stored as pending. It becomes active on the cycle after the last cycle of the current correction period. A write made during that last cycle waits for the following period.
- R7: Event output n pulses for one cycle after an enabled cycle in which prescaler bit n goes from 0 to 1.
- R8: Event output n stays low whenever `evt_en_i[n]` was low at the edge where its rise would have been seen.
- R9: A magnitude of 0 applies no correction. The largest magnitude, `2**MAG_W-1`, adjusts every one of the last `2**MAG_W-1` sub-periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Count enable |
| corr_we_i | input | 1 | Trim write strobe |
| corr_wdata_i | input | MAG_W+1 | Trim word: MSB is the sign (1 = slower), lower bits are the magnitude |
| evt_en_i | input | NEV | Per-bit periodic event enable |
| tick_o | output | 1 | Prescaled tick to the counter |
| evt_o | output | NEV | Periodic event pulses |

## Verification
A wrong position in the correction period, or a wrong active trim, has no effect until an adjustment cycle is reached or missed. From then on, the prescaler phase stays offset for good. Every later tick and every later low-bit event pulse arrive one or more cycles early or late, and the mismatch is visible on the first event pulse after the fault. The bench runs a behavioural model alongside the design and compares the tick and the event vector on every cycle, so such a phase slip shows up within a couple of cycles of the wrong adjustment. A trim loaded at the wrong period boundary shows up as adjustments shifted by a full period.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

   // Amount the prescaler advances on one enabled source cycle
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_ONE  = 2'd1,
      STEP_TWO  = 2'd2
   } step_e;

endpackage

// File: rtl/rtc_trim_window.sv
// Tracks the position inside the correction period, keeps the pending and
// active trim words, and decides the prescaler step for each cycle.
module rtc_trim_window
   import rtc_trim_pkg::*;
#(
   parameter int SUB_W   = 10,
   parameter int NUM_SUB = 976,
   parameter int MAG_W   = 7
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic             we_i,
   input  logic [MAG_W:0]   wdata_i,
   output step_e            step_o,
   output logic             wrap_o,
   output logic             act_neg_o,
   output logic [MAG_W-1:0] act_mag_o
);

   localparam int SIDX_W = $clog2(NUM_SUB);
   localparam logic [SIDX_W-1:0] LAST_SUB  = SIDX_W'(NUM_SUB - 1);
   localparam logic [SIDX_W:0]   NUM_SUB_X = (SIDX_W + 1)'(NUM_SUB);

   logic [SUB_W-1:0]  off_q;
   logic [SIDX_W-1:0] sub_q;
   logic [MAG_W:0]    pend_q;
   logic [MAG_W:0]    act_q;

   logic              off_last;
   logic              sub_last;
   logic [SIDX_W:0]   first_adj;
   logic              in_window;
   logic              adj_cycle;

   assign off_last  = &off_q;
   assign sub_last  = (sub_q == LAST_SUB);
   assign wrap_o    = en_i & off_last & sub_last;
   assign act_neg_o = act_q[MAG_W];
   assign act_mag_o = act_q[MAG_W-1:0];

   // First sub-period that gets an adjustment: NUM_SUB - magnitude
   assign first_adj = NUM_SUB_X - {{(SIDX_W + 1 - MAG_W){1'b0}}, act_mag_o};
   assign in_window = (act_mag_o != '0) && ({1'b0, sub_q} >= first_adj);
   assign adj_cycle = en_i && (off_q == '0) && in_window;

   always_comb begin
      if (!adj_cycle)     step_o = STEP_ONE;
      else if (act_neg_o) step_o = STEP_HOLD;
      else                step_o = STEP_TWO;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         off_q  <= '0;
         sub_q  <= '0;
         pend_q <= '0;
         act_q  <= '0;
      end else begin
         if (we_i)   pend_q <= wdata_i;
         if (wrap_o) act_q  <= pend_q;
         if (en_i) begin
            off_q <= off_q + 1'b1;
            if (off_last) sub_q <= sub_last ? '0 : sub_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/rtc_trim_divider.sv
// Prescaler counter that advances by the chosen step; carry-out gives the
// tick and per-bit rising edges give the periodic events.
module rtc_trim_divider
   import rtc_trim_pkg::*;
#(
   parameter int PRESC_W = 10,
   parameter int NEV     = 8
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               en_i,
   input  step_e              step_i,
   input  logic [NEV-1:0]     evt_en_i,
   output logic               tick_o,
   output logic [NEV-1:0]     evt_o,
   output logic [PRESC_W-1:0] presc_o
);

   logic [PRESC_W-1:0] presc_q;
   logic [PRESC_W:0]   sum;
   logic [PRESC_W-1:0] nxt;
   logic [NEV-1:0]     rise;

   assign sum     = {1'b0, presc_q} + {{(PRESC_W - 1){1'b0}}, step_i};
   assign nxt     = sum[PRESC_W-1:0];
   assign presc_o = presc_q;

   for (genvar n = 0; n < NEV; n++) begin : g_evt
      assign rise[n] = evt_en_i[n] & ~presc_q[n] & nxt[n];
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         presc_q <= '0;
         tick_o  <= 1'b0;
         evt_o   <= '0;
      end else if (en_i) begin
         presc_q <= nxt;
         tick_o  <= sum[PRESC_W];
         evt_o   <= rise;
      end else begin
         tick_o  <= 1'b0;
         evt_o   <= '0;
      end
   end

endmodule

// File: rtl/rtc_trim_presc.sv
module rtc_trim_presc
   import rtc_trim_pkg::*;
#(
   parameter int PRESC_W = 10,
   parameter int NEV     = 8,
   parameter int SUB_W   = 10,
   parameter int NUM_SUB = 976,
   parameter int MAG_W   = 7
) (
   input  logic           clk_i,
   input  logic           rst_i,
   input  logic           en_i,
   input  logic           corr_we_i,
   input  logic [MAG_W:0] corr_wdata_i,
   input  logic [NEV-1:0] evt_en_i,
   output logic           tick_o,
   output logic [NEV-1:0] evt_o
);

   localparam int MAX_MAG = (1 << MAG_W) - 1;

   // Elaboration-time parameter checks
   if (PRESC_W < 2) begin : g_bad_presc
      $error("PRESC_W must be at least 2");
   end
   if (NEV < 1 || NEV > PRESC_W) begin : g_bad_nev
      $error("NEV must lie in 1..PRESC_W");
   end
   if (MAG_W < 2) begin : g_bad_mag
      $error("MAG_W must be at least 2");
   end
   if (NUM_SUB < MAX_MAG + 1) begin : g_bad_sub
      $error("NUM_SUB must exceed the largest trim magnitude");
   end
   if (SUB_W < 1) begin : g_bad_subw
      $error("SUB_W must be at least 1");
   end

   step_e              step;
   logic               wrap;
   logic               act_neg;
   logic [MAG_W-1:0]   act_mag;
   logic [PRESC_W-1:0] presc;

   rtc_trim_window #(
      .SUB_W   (SUB_W),
      .NUM_SUB (NUM_SUB),
      .MAG_W   (MAG_W)
   ) u_window (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .en_i      (en_i),
      .we_i      (corr_we_i),
      .wdata_i   (corr_wdata_i),
      .step_o    (step),
      .wrap_o    (wrap),
      .act_neg_o (act_neg),
      .act_mag_o (act_mag)
   );

   rtc_trim_divider #(
      .PRESC_W (PRESC_W),
      .NEV     (NEV)
   ) u_divider (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .en_i     (en_i),
      .step_i   (step),
      .evt_en_i (evt_en_i),
      .tick_o   (tick_o),
      .evt_o    (evt_o),
      .presc_o  (presc)
   );

endmodule

// File: rtl/rtc_trim_presc_chk.sv
module rtc_trim_presc_chk #(
   parameter int PRESC_W = 10,
   parameter int NEV     = 8,
   parameter int MAG_W   = 7
) (
   input logic               clk_i,
   input logic               rst_i,
   input logic               en_i,
   input logic [NEV-1:0]     evt_en_i,
   input logic               tick_o,
   input logic [NEV-1:0]     evt_o,
   input logic [PRESC_W-1:0] presc,
   input logic               wrap,
   input logic               act_neg,
   input logic [MAG_W-1:0]   act_mag
);

   assert_quiet_disabled_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> (!tick_o && evt_o == '0));

   assert_hold_disabled_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> $stable(presc));

   assert_tick_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      tick_o |=> !tick_o);

   assert_tick_at_wrap_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      tick_o |-> (presc < PRESC_W'(2)));

   assert_evt_gated_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      en_i |=> ((evt_o & ~$past(evt_en_i)) == '0));

   assert_evt_pulse_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (evt_o != '0) |=> ((evt_o & $past(evt_o)) == '0));

   assert_fast_moves_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && !act_neg) |=> (presc != $past(presc)));

   assert_slow_no_skip_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && act_neg) |=> (PRESC_W'(presc - $past(presc)) != PRESC_W'(2)));

   assert_trim_stable_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      !wrap |=> $stable({act_neg, act_mag}));

endmodule

bind rtc_trim_presc rtc_trim_presc_chk #(
   .PRESC_W (PRESC_W),
   .NEV     (NEV),
   .MAG_W   (MAG_W)
) u_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .en_i     (en_i),
   .evt_en_i (evt_en_i),
   .tick_o   (tick_o),
   .evt_o    (evt_o),
   .presc    (presc),
   .wrap     (wrap),
   .act_neg  (act_neg),
   .act_mag  (act_mag)
);

// File: tb/rtc_trim_presc_test.sv
`timescale 1ns/1ps
module rtc_trim_presc_test;

   localparam int PW      = 8;
   localparam int NEV     = 8;
   localparam int SUB_W   = 3;
   localparam int NUM_SUB = 140;
   localparam int MAG_W   = 7;
   localparam int SUB_LEN = 1 << SUB_W;
   localparam int PERIOD  = SUB_LEN * NUM_SUB;
   localparam int MAGMOD  = 1 << MAG_W;

   logic           clk = 1'b0;
   logic           rst;
   logic           en;
   logic           we;
   logic [MAG_W:0] wdata;
   logic [NEV-1:0] evt_en;
   logic           tick_o;
   logic [NEV-1:0] evt_o;

   int    checks = 0;
   int    fails  = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   rtc_trim_presc #(
      .PRESC_W (PW),
      .NEV     (NEV),
      .SUB_W   (SUB_W),
      .NUM_SUB (NUM_SUB),
      .MAG_W   (MAG_W)
   ) uut (
      .clk_i        (clk),
      .rst_i        (rst),
      .en_i         (en),
      .corr_we_i    (we),
      .corr_wdata_i (wdata),
      .evt_en_i     (evt_en),
      .tick_o       (tick_o),
      .evt_o        (evt_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference model
   int             m_cnt, m_pres, m_pend, m_act;
   logic           m_tick;
   logic [NEV-1:0] m_evt;

   always @(posedge clk) begin
      if (rst) begin
         m_cnt = 0; m_pres = 0; m_pend = 0; m_act = 0;
         m_tick = 1'b0; m_evt = '0;
      end else begin : mdl
         int sub, off, mag, step, np;
         bit neg;
         if (en) begin
            sub  = m_cnt / SUB_LEN;
            off  = m_cnt % SUB_LEN;
            mag  = m_act % MAGMOD;
            neg  = (m_act / MAGMOD) != 0;
            step = 1;
            if (mag != 0 && off == 0 && sub >= NUM_SUB - mag) step = neg ? 0 : 2;
            np     = m_pres + step;
            m_tick = (np >= (1 << PW));
            np     = np % (1 << PW);
            for (int n = 0; n < NEV; n++)
               m_evt[n] = evt_en[n] && (((m_pres >> n) & 1) == 0) && (((np >> n) & 1) == 1);
            m_pres = np;
            if (m_cnt == PERIOD - 1) begin
               m_cnt = 0;
               m_act = m_pend;
            end else begin
               m_cnt++;
            end
         end else begin
            m_tick = 1'b0;
            m_evt  = '0;
         end
         if (we) m_pend = int'(wdata);
      end
   end

   // Per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         chk(cur_req, int'(tick_o), int'(m_tick));
         chk(cur_req, int'(evt_o), int'(m_evt));
      end
   end

   task automatic write_trim(input logic neg, input int mag);
      we    = 1'b1;
      wdata = {neg, MAG_W'(mag)};
      @(negedge clk);
      we    = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (120000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int n;
      rst = 1'b1; en = 1'b0; we = 1'b0; wdata = '0; evt_en = '0;
      repeat (4) @(negedge clk);
      chk("R1", int'(tick_o), 0);
      chk("R1", int'(evt_o), 0);

      rst = 1'b0; en = 1'b1; evt_en = '1; cur_req = "R2/R7";
      n = 0;
      do begin @(negedge clk); n++; end while (!tick_o && n < 1000);
      chk("R1", n, 1 << PW);
      n = 0;
      do begin @(negedge clk); n++; end while (!tick_o && n < 1000);
      chk("R2", n, 1 << PW);
      repeat (900) @(negedge clk);

      // Positive trim written mid-period
      cur_req = "R4/R6";
      write_trim(1'b0, 5);
      repeat (2 * PERIOD + 50) @(negedge clk);

      // Largest negative trim with a sparse event select
      cur_req = "R5/R8/R9";
      evt_en = 8'hA5;
      write_trim(1'b1, MAGMOD - 1);
      repeat (2 * PERIOD) @(negedge clk);

      // Enable gating
      cur_req = "R3";
      for (int i = 0; i < 300; i++) begin
         en = ((i % 7) < 4);
         @(negedge clk);
      end
      en = 1'b0;
      write_trim(1'b0, 3);
      repeat (20) @(negedge clk);
      en = 1'b1;

      // Write landing in the last cycle of a period
      cur_req = "R6/R9";
      evt_en = 8'h5A;
      while (m_cnt != PERIOD - 1) @(negedge clk);
      write_trim(1'b0, MAGMOD - 1);
      repeat (2 * PERIOD + 20) @(negedge clk);

      // Back to no correction
      cur_req = "R9/R2";
      evt_en = '1;
      write_trim(1'b1, 0);
      repeat (2 * PERIOD) @(negedge clk);
      n = 0;
      do begin @(negedge clk); n++; end while (!tick_o && n < 1000);
      n = 0;
      do begin @(negedge clk); n++; end while (!tick_o && n < 1000);
      chk("R9", n, 1 << PW);

      finish_run();
   end

endmodule